// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder with Strobed Tri-State Output

The block adds two IEEE 754 single-precision operands and delivers the single-precision sum on a shared 32-bit tri-state bus. A load strobe copies both operands into internal registers. A combinational datapath works on those registers. It unpacks the fields, compares exponents, aligns the smaller significand with guard, round and sticky bits, adds or subtracts, normalizes, rounds to nearest-even and packs the result. It accepts and produces NaN, both infinities, both zeros, normal numbers and subnormal numbers.

A drive strobe controls the bus. The first drive strobe captures the sum and the two flags into output registers and turns the bus driver on. The next drive strobe turns the driver off again and returns the bus to high impedance. An enable output shows the driver state, so neighbours sharing the bus can arbitrate.

Top module: `fp_add_bus`

## Requirements
- R1: On a rising clock edge with `ld_i` high, `opa_i` and `opb_i` are stored. Changes on the operand inputs with `ld_i` low have no effect on any later result.
- R2: On a rising edge with `drv_i` high and the bus released, the sum of the stored operands and its flags are captured. `bus_en_o` is 1 and `sum_bus` carries the sum from that edge on.
- R3: On a rising edge with `drv_i` high and the bus driven, `bus_en_o` returns to 0 and the bus is released. While the bus is driven, the bus value and the flags stay unchanged, even when new operands are loaded.
- R4: Finite sums and differences are rounded to nearest, with ties to even. The rounding uses guard, round and sticky bits that are kept through alignment and through normalization.
- R5: If either operand is a NaN (exponent field 255, fraction non-zero), the result is 0x7FC00000. Infinities of opposite sign also give 0x7FC00000.
- R6: An infinity added to a finite value, or to an infinity of the same sign, returns that infinity, and `ovf_o` stays 0.
- R7: If a finite sum rounds to an exponent field of 255, the result is the infinity with the sum's sign and `ovf_o` is 1. Otherwise `ovf_o` is 0.
- R8: Equal magnitudes of opposite sign give +0 (0x00000000). Two negative zeros give -0 (0x80000000).
- R9: An operand with exponent field 0 is treated as having exponent 1 and no hidden bit. A result below the smallest normal magnitude is returned as a subnormal and is not flushed to zero.
- R10: `unf_o` is bit 8 of the 9-bit value (larger exponent − leading zero count − 1). The flag is 1 when the non-zero result before rounding lies below the normal range, and 0 for zero and normal results.
- R11: If the exponent difference is 26 or more, the smaller operand contributes only to the sticky bit.
- R12: After reset, `bus_en_o`, `ovf_o` and `unf_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ld_i | input | 1 | Load strobe for the operands |
| opa_i | input | 32 | First operand, single precision |
| opb_i | input | 32 | Second operand, single precision |
| drv_i | input | 1 | Drive strobe: toggles the bus driver |
| sum_bus | output | 32 | Tri-state result bus, high impedance when released |
| bus_en_o | output | 1 | 1 while the block drives `sum_bus` |
| ovf_o | output | 1 | Overflow flag of the captured result |
| unf_o | output | 1 | Underflow flag of the captured result |

## Verification
The datapath has no pipeline stages, so a fault in alignment, normalization or rounding shows on the bus at the first drive pulse after the load. The typical sign is a last-place error on a tie or on a long-shift sticky case, or a subnormal whose exponent field is 1 instead of 0. A wrong driver state cannot be hidden: the enable output fails to toggle one edge after a drive pulse. A loaded value that leaks into a held bus word changes the bus while it is driven.

// File: rtl/fp_add_bus.sv
module fp_add_bus #(
  parameter int EW = 8,
  parameter int FW = 23
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ld_i,
  input  logic [EW+FW:0]      opa_i,
  input  logic [EW+FW:0]      opb_i,
  input  logic                drv_i,
  output wire  [EW+FW:0]      sum_bus,
  output logic                bus_en_o,
  output logic                ovf_o,
  output logic                unf_o
);
  localparam int W  = EW + FW + 1;
  localparam int MW = FW + 1;
  localparam int AW = MW + 3;
  localparam int XW = 2 * MW + 2;
  localparam int LZW = $clog2(AW + 1);
  localparam logic [W-1:0] QNAN = {1'b0, {EW{1'b1}}, 1'b1, {(FW-1){1'b0}}};
  localparam logic [W-2:0] INFM = {{EW{1'b1}}, {FW{1'b0}}};

  logic [W-1:0] ra, rb, res, out_q;
  logic         ovf_c, unf_c;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ra <= '0;
      rb <= '0;
    end else if (ld_i) begin
      ra <= opa_i;
      rb <= opb_i;
    end
  end

  logic a_nan, b_nan, a_inf, b_inf;
  assign a_nan = (&ra[W-2:FW]) && (|ra[FW-1:0]);
  assign b_nan = (&rb[W-2:FW]) && (|rb[FW-1:0]);
  assign a_inf = (&ra[W-2:FW]) && !(|ra[FW-1:0]);
  assign b_inf = (&rb[W-2:FW]) && !(|rb[FW-1:0]);

  logic [W-1:0]   big, sml;
  logic [EW-1:0]  e_l, e_s, dexp;
  logic [MW-1:0]  m_l, m_s;
  logic           sub;

  assign big  = (rb[W-2:0] > ra[W-2:0]) ? rb : ra;
  assign sml  = (rb[W-2:0] > ra[W-2:0]) ? ra : rb;
  assign e_l  = (big[W-2:FW] == '0) ? EW'(1) : big[W-2:FW];
  assign e_s  = (sml[W-2:FW] == '0) ? EW'(1) : sml[W-2:FW];
  assign m_l  = {|big[W-2:FW], big[FW-1:0]};
  assign m_s  = {|sml[W-2:FW], sml[FW-1:0]};
  assign dexp = e_l - e_s;
  assign sub  = big[W-1] ^ sml[W-1];

  logic [XW-1:0]  ext;
  logic [AW-1:0]  al;
  logic [AW:0]    s;
  assign ext = {m_s, {(MW+2){1'b0}}} >> dexp;
  assign al  = (dexp >= EW'(MW + 2)) ? {{(AW-1){1'b0}}, |m_s}
                                     : {ext[XW-1:MW], |ext[MW-1:0]};
  assign s   = sub ? ({1'b0, m_l, 3'b000} - {1'b0, al})
                   : ({1'b0, m_l, 3'b000} + {1'b0, al});

  logic [LZW-1:0] lz, sh;
  always_comb begin
    lz = LZW'(AW);
    for (int i = 0; i < AW; i++)
      if (s[i]) lz = LZW'(AW - 1 - i);
  end

  logic [EW:0]    t9, ep;
  logic           tiny, carry;
  logic [AW-1:0]  n;
  assign t9    = {1'b0, e_l} - {{(EW+1-LZW){1'b0}}, lz} - (EW+1)'(1);
  assign tiny  = t9[EW];
  assign carry = s[AW];
  assign sh    = tiny ? LZW'(e_l - EW'(1)) : lz;

  always_comb begin
    if (carry) begin
      n  = {s[AW:2], |s[1:0]};
      ep = {1'b0, e_l} + (EW+1)'(1);
    end else begin
      n  = s[AW-1:0] << sh;
      ep = tiny ? '0 : t9 + (EW+1)'(1);
    end
  end

  logic [MW-1:0]  mant;
  logic           inc;
  logic [MW:0]    rm;
  logic [W-1:0]   packed_v;
  assign mant = n[AW-1:3];
  assign inc  = n[2] & (n[1] | n[0] | n[3]);
  assign rm   = {1'b0, mant} + {{MW{1'b0}}, inc};
  assign packed_v = (ep == '0) ? {{(W-MW-1){1'b0}}, rm}
                  : ({{(W-EW-1){1'b0}}, ep - (EW+1)'(1)} << FW)
                    + {{(W-MW-1){1'b0}}, rm};

  always_comb begin
    ovf_c = 1'b0;
    unf_c = 1'b0;
    if (a_nan || b_nan || (a_inf && b_inf && (ra[W-1] != rb[W-1])))
      res = QNAN;
    else if (a_inf)
      res = ra;
    else if (b_inf)
      res = rb;
    else if (s == '0)
      res = {big[W-1] & ~sub, {(W-1){1'b0}}};
    else if (packed_v >= {1'b0, INFM}) begin
      res   = {big[W-1], INFM};
      ovf_c = 1'b1;
    end else begin
      res   = {big[W-1], packed_v[W-2:0]};
      unf_c = tiny & ~carry;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q    <= '0;
      bus_en_o <= 1'b0;
      ovf_o    <= 1'b0;
      unf_o    <= 1'b0;
    end else if (drv_i) begin
      if (bus_en_o) begin
        bus_en_o <= 1'b0;
      end else begin
        bus_en_o <= 1'b1;
        out_q    <= res;
        ovf_o    <= ovf_c;
        unf_o    <= unf_c;
      end
    end
  end

  assign sum_bus = bus_en_o ? out_q : 'z;

  AST_LOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_i |=> ($stable(ra) && $stable(rb))); // R1
  AST_DRV_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    drv_i |=> (bus_en_o != $past(bus_en_o))); // R2
  AST_BUS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en_o && !drv_i) |=> ($stable(out_q) && $stable(ovf_o) && $stable(unf_o))); // R3
  AST_NAN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_i && !bus_en_o && (a_nan || b_nan)) |=> (out_q == QNAN)); // R5
  AST_OVF_INF: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en_o && ovf_o) |-> (out_q[W-2:0] == INFM)); // R7
  AST_UNF_SMALL: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en_o && unf_o) |-> (out_q[W-2:FW+1] == '0 && !ovf_o)); // R10
endmodule

// File: tb/fp_add_bus_bench.sv
module fp_add_bus_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_i = 1'b0, drv_i = 1'b0;
  logic [31:0] opa_i = '0, opb_i = '0;
  wire  [31:0] sum_bus;
  logic bus_en_o, ovf_o, unf_o;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  fp_add_bus u_fp_add_bus (
    .clk(clk), .rst_n(rst_n), .ld_i(ld_i), .opa_i(opa_i), .opb_i(opb_i),
    .drv_i(drv_i), .sum_bus(sum_bus), .bus_en_o(bus_en_o),
    .ovf_o(ovf_o), .unf_o(unf_o));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic load(input logic [31:0] a, input logic [31:0] b);
    @(negedge clk); opa_i = a; opb_i = b; ld_i = 1'b1;
    @(negedge clk); ld_i = 1'b0;
  endtask

  task automatic pulse_drv;
    drv_i = 1'b1;
    @(negedge clk); drv_i = 1'b0;
  endtask

  task automatic add_case(input string tag, input logic [31:0] a, input logic [31:0] b,
                          input logic [31:0] exp, input logic eo, input logic eu);
    load(a, b);
    pulse_drv();
    chk({tag, " bus_en"}, {31'b0, bus_en_o}, 32'd1);
    chk({tag, " sum"}, sum_bus, exp);
    chk({tag, " ovf"}, {31'b0, ovf_o}, {31'b0, eo});
    chk({tag, " unf"}, {31'b0, unf_o}, {31'b0, eu});
    pulse_drv();
    chk({tag, " release"}, {31'b0, bus_en_o}, 32'd0);
  endtask

  task automatic t_reset;
    chk("R12 en", {31'b0, bus_en_o}, 32'd0);
    chk("R12 ovf", {31'b0, ovf_o}, 32'd0);
    chk("R12 unf", {31'b0, unf_o}, 32'd0);
  endtask

  task automatic t_normal;
    add_case("R2 R4 1+1", 32'h3F800000, 32'h3F800000, 32'h40000000, 0, 0);
    add_case("R4 1-0.5", 32'h3F800000, 32'hBF000000, 32'h3F000000, 0, 0);
    add_case("R4 1.5+2.5", 32'h3FC00000, 32'h40200000, 32'h40800000, 0, 0);
    add_case("R4 tie even", 32'h3F800000, 32'h33800000, 32'h3F800000, 0, 0);
    add_case("R4 tie odd", 32'h3F800001, 32'h33800000, 32'h3F800002, 0, 0);
  endtask

  task automatic t_far;
    add_case("R11 far add", 32'h3F800000, 32'h30800000, 32'h3F800000, 0, 0);
    add_case("R11 far sub", 32'h3F800000, 32'hB0800000, 32'h3F800000, 0, 0);
  endtask

  task automatic t_special;
    add_case("R5 qnan", 32'h7FC00001, 32'h3F800000, 32'h7FC00000, 0, 0);
    add_case("R5 snan b", 32'h3F800000, 32'h7F800001, 32'h7FC00000, 0, 0);
    add_case("R5 inf-inf", 32'h7F800000, 32'hFF800000, 32'h7FC00000, 0, 0);
    add_case("R6 inf+1", 32'h7F800000, 32'h3F800000, 32'h7F800000, 0, 0);
    add_case("R6 1-inf", 32'h3F800000, 32'hFF800000, 32'hFF800000, 0, 0);
    add_case("R6 inf+inf", 32'h7F800000, 32'h7F800000, 32'h7F800000, 0, 0);
  endtask

  task automatic t_overflow;
    add_case("R7 pos ovf", 32'h7F7FFFFF, 32'h7F7FFFFF, 32'h7F800000, 1, 0);
    add_case("R7 neg ovf", 32'hFF7FFFFF, 32'hFF7FFFFF, 32'hFF800000, 1, 0);
  endtask

  task automatic t_zero;
    add_case("R8 x-x", 32'h3F800000, 32'hBF800000, 32'h00000000, 0, 0);
    add_case("R8 -x+x", 32'hC0400000, 32'h40400000, 32'h00000000, 0, 0);
    add_case("R8 -0+-0", 32'h80000000, 32'h80000000, 32'h80000000, 0, 0);
    add_case("R8 +0+-0", 32'h00000000, 32'h80000000, 32'h00000000, 0, 0);
  endtask

  task automatic t_denorm;
    add_case("R9 R10 den+den", 32'h00000001, 32'h00000001, 32'h00000002, 0, 1);
    add_case("R9 R10 to normal", 32'h00400000, 32'h00400000, 32'h00800000, 0, 0);
    add_case("R9 R10 min-den", 32'h00800000, 32'h80000001, 32'h007FFFFF, 0, 1);
    add_case("R9 R10 norm-norm", 32'h00C00000, 32'h80800000, 32'h00400000, 0, 1);
  endtask

  task automatic t_protocol;
    load(32'h3F800000, 32'h3F800000);
    @(negedge clk); opa_i = 32'h40400000; opb_i = 32'h40400000;
    @(negedge clk);
    pulse_drv();
    chk("R1 ignored inputs", sum_bus, 32'h40000000);
    load(32'h40400000, 32'h40400000);
    @(negedge clk);
    chk("R3 bus held", sum_bus, 32'h40000000);
    chk("R3 still driven", {31'b0, bus_en_o}, 32'd1);
    pulse_drv();
    chk("R3 released", {31'b0, bus_en_o}, 32'd0);
    pulse_drv();
    chk("R2 new sum", sum_bus, 32'h40C00000);
    pulse_drv();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_normal();
    t_far();
    t_special();
    t_overflow();
    t_zero();
    t_denorm();
    t_protocol();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule